// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave-side control logic of a small two-wire serial EEPROM. It oversamples SCL and SDA on a fast system clock through a synchroniser and finds START and STOP conditions. It decodes the device select byte and runs four transfers: byte write, current-address read, random read and sequential read. It drives the bus only by pulling SDA low through an open-drain enable. A register array stands in for the storage. A countdown timer models the programming time after each committed write.

The engine is built to survive a master that stops in the middle of a transfer. A START at any bit abandons the transfer and waits for a new select byte. A STOP at any bit returns the engine to standby. A write is committed only when the STOP comes after the acknowledge clock of a complete data byte. Neither kind of abort moves the address counter.

The engine can hold SDA low in the middle of a read byte. A master can then bring it back by pulsing SCL until the engine lets SDA go, and then issuing START and STOP. The bus carries single bits, not words, so the block has no valid/ready stream port. All of its pins are plain levels.

Top module: `eeprom_serial_engine`

## Requirements
- R1: START is SDA falling while SCL is high, as seen after the synchroniser. It aborts whatever transfer is running, releases SDA, and makes the next eight bits a device select byte.
- R2: STOP is SDA rising while SCL is high. It aborts any transfer, releases SDA and leaves the engine idle.
- R3: The select byte is sent MSB first. Its upper seven bits must equal DEV_CODE (default 1010000b), and bit 0 selects the direction (1 = read, 0 = write). On a match the engine acknowledges by pulling SDA low for the ninth clock. On a mismatch it stays released and ignores the bus until the next START or STOP.
- R4: A write is the select byte with bit 0 clear, then a word address byte, then one data byte. The engine acknowledges each byte. The low ADDR_W bits of the address byte are loaded into the address counter.
- R5: A STOP that follows the ninth clock of a completed data byte commits that byte to the addressed word. It sets the counter to that address plus one and raises write_busy for WR_CYCLES clocks. A STOP part way through the data byte commits nothing. So does a START after the data byte. In neither case is write_busy raised.
- R6: While write_busy is high, the engine does not acknowledge its select byte.
- R7: A read sends the word at the address counter, MSB first. SDA only changes while SCL is low. The counter steps by one for each byte sent and wraps at 2^ADDR_W.
- R8: A read select byte sent straight after START uses the current counter value. A random read loads the counter with a write select byte and an address byte, then uses a repeated START and a read select byte.
- R9: During a read, if the master pulls SDA low on the ninth clock the next byte follows. A NoAck instead ends the read, and SDA stays released until START or STOP.
- R10: On the ninth clock of every read byte the engine releases SDA.
- R11: The engine may be holding SDA low when the master stops. SCL pulses, each carrying a START attempt, followed by a STOP, then bring it back to idle with SDA released. The address counter keeps the value it had when the transfer was abandoned.
- R12: After reset SDA is released, write_busy is low, the address counter is 0 and every stored word is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level (asynchronous) |
| sda_i | input | 1 | Bus data level as seen on the wire (asynchronous) |
| sda_drive_low | output | 1 | 1 pulls the SDA wire low; 0 releases it |
| write_busy | output | 1 | High while a committed write is being programmed |

## Verification
A wrong phase shows on sda_drive_low within one SCL period. Examples are a missing or extra acknowledge, or read data at the wrong bit or byte. The bench compares this pin against its model on every system clock, outside a short settling window after each SCL edge. A wrong address counter shows only in the data of the next current-address read. Each abort test therefore ends with such a read, using data that is unique to one address. A wrongly committed write shows as write_busy rising a few clocks after the STOP, and later as changed read data.

// File: rtl/eeprom_eng_pkg.sv
package eeprom_eng_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEVSEL,
    PH_ADDR,
    PH_WDATA,
    PH_READ,
    PH_IGNORE
  } phase_t;
endpackage

// File: rtl/bus_event_detect.sv
module bus_event_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[SYNC_STAGES-1];
      sda_prev <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  // data edge while the clock is held high on both samples
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/byte_store.sv
module byte_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             words[i] <= '0;
      else if (we && waddr == ADDR_W'(i))     words[i] <= wdata;
    end
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/write_timer.sv
module write_timer #(
  parameter int WR_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (launch)         remain <= CW'(WR_CYCLES);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/eeprom_serial_engine.sv
module eeprom_serial_engine
  import eeprom_eng_pkg::*;
#(
  parameter logic [6:0] DEV_CODE    = 7'b1010000,
  parameter int         ADDR_W      = 4,
  parameter int         WR_CYCLES   = 64,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_drive_low,
  output logic write_busy
);
  localparam int BYTE_W = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  phase_t phase;
  logic [3:0]        bit_cnt;     // SCL rising edges seen in the current byte
  logic [BYTE_W-1:0] shreg;       // receive shifter, or transmit shifter in PH_READ
  logic [ADDR_W-1:0] addr_q, wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q, rd_word;
  logic              wr_pend, m_ack, ack_ok, launch;

  bus_event_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign launch = stop_det & wr_pend;

  byte_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(launch), .waddr(wr_addr_q),
    .wdata(wr_data_q), .raddr(addr_q), .rdata(rd_word)
  );

  write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(write_busy)
  );

  always_comb begin
    ack_ok = 1'b1;
    if (phase == PH_DEVSEL) ack_ok = (shreg[7:1] == DEV_CODE) && !write_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_IDLE;
      bit_cnt       <= '0;
      shreg         <= '0;
      addr_q        <= '0;
      wr_addr_q     <= '0;
      wr_data_q     <= '0;
      wr_pend       <= 1'b0;
      m_ack         <= 1'b0;
      sda_drive_low <= 1'b0;
    end else if (start_det) begin
      phase         <= PH_DEVSEL;
      bit_cnt       <= '0;
      wr_pend       <= 1'b0;
      sda_drive_low <= 1'b0;
    end else if (stop_det) begin
      phase         <= PH_IDLE;
      bit_cnt       <= '0;
      wr_pend       <= 1'b0;
      sda_drive_low <= 1'b0;
      if (wr_pend) addr_q <= wr_addr_q + 1'b1;
    end else begin
      unique case (phase)
        PH_DEVSEL, PH_ADDR, PH_WDATA: begin
          if (scl_rise) begin
            if (bit_cnt < 4'd8) shreg <= {shreg[BYTE_W-2:0], sda_s};
            if (bit_cnt < 4'd9) bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            sda_drive_low <= ack_ok;
          end else if (scl_fall && bit_cnt == 4'd9) begin
            sda_drive_low <= 1'b0;
            bit_cnt       <= '0;
            if (!sda_drive_low) begin
              phase <= PH_IGNORE;
            end else if (phase == PH_DEVSEL) begin
              if (shreg[0]) begin
                phase         <= PH_READ;
                shreg         <= rd_word;
                addr_q        <= addr_q + 1'b1;
                sda_drive_low <= ~rd_word[BYTE_W-1];
              end else begin
                phase <= PH_ADDR;
              end
            end else if (phase == PH_ADDR) begin
              addr_q <= shreg[ADDR_W-1:0];
              phase  <= PH_WDATA;
            end else begin
              wr_addr_q <= addr_q;
              wr_data_q <= shreg;
              wr_pend   <= 1'b1;
              phase     <= PH_IGNORE;
            end
          end
        end
        PH_READ: begin
          if (scl_rise) begin
            if (bit_cnt == 4'd8) m_ack <= ~sda_s;
            if (bit_cnt < 4'd9) bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt < 4'd8) begin
              sda_drive_low <= ~shreg[BYTE_W-2];
              shreg         <= {shreg[BYTE_W-2:0], 1'b0};
            end else if (bit_cnt == 4'd8) begin
              sda_drive_low <= 1'b0;
            end else begin
              bit_cnt <= '0;
              if (m_ack) begin
                shreg         <= rd_word;
                addr_q        <= addr_q + 1'b1;
                sda_drive_low <= ~rd_word[BYTE_W-1];
              end else begin
                sda_drive_low <= 1'b0;
                phase         <= PH_IGNORE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_engine_chk.sv
module eeprom_engine_chk
  import eeprom_eng_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input phase_t            phase,
  input logic [ADDR_W-1:0] addr_q,
  input logic              drive_low,
  input logic              busy
);
  // R1
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase == PH_DEVSEL && !drive_low));
  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (phase == PH_IDLE && !drive_low));
  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> $stable(addr_q));
  // R5
  busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));
  // R6
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == PH_DEVSEL) |-> !drive_low);
  // R7
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drive_low) |-> !$past(scl_s));
endmodule

bind eeprom_serial_engine eeprom_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .phase(phase), .addr_q(addr_q),
  .drive_low(sda_drive_low), .busy(write_busy)
);

// File: tb/sim_eeprom_serial_engine.sv
module sim_eeprom_serial_engine;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;     // system clocks per quarter bit
  localparam int WRC        = 600;
  localparam logic [7:0] DEVW = 8'hA0;
  localparam logic [7:0] DEVR = 8'hA1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_drive_low, write_busy;
  wire  bus_sda = m_sda & ~sda_drive_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_serial_engine #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
    .sda_drive_low(sda_drive_low), .write_busy(write_busy)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] mdl_mem [16];
  int   mdl_addr = 0;
  logic exp_drive = 1'b0;
  int   settle = 0;
  bit   cmp_on = 1'b0;
  logic s;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model of the SDA pin, compared every clock away from the edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      if (settle > 0) settle--;
      else chk(sda_drive_low === exp_drive, "R10 R7 R3 per-clock sda", sda_drive_low, exp_drive);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clock_bit(input logic v, input logic nxt, output logic seen);
    m_sda = v; tick(Q);
    m_scl = 1'b1; tick(Q);
    seen = bus_sda; tick(Q);
    m_scl = 1'b0; exp_drive = nxt; settle = 5; tick(Q);
  endtask

  task automatic gen_start;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; exp_drive = 1'b0; settle = 5; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic gen_stop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; exp_drive = 1'b0; settle = 5; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input logic nxt, input string req);
    logic sn;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], (i == 0) ? exp_ack : 1'b0, sn);
    clock_bit(1'b1, nxt, sn);
    chk(sn == !exp_ack, req, sn, !exp_ack);
  endtask

  task automatic read_byte(input logic [7:0] b, input logic mack, input logic nxt, input string req);
    logic sn;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, (i > 0) ? ~b[i-1] : 1'b0, sn);
      chk(sn == b[i], req, sn, b[i]);
    end
    clock_bit(!mack, nxt, sn);
    // R10: the engine leaves the ninth bit to the master
    chk(sn == !mack, "R10 ninth clock released", sn, !mack);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    gen_start;
    send_byte(DEVW, 1'b1, 1'b0, "R3 write select ack");
    send_byte({4'h0, a}, 1'b1, 1'b0, "R4 address ack");
    send_byte(d, 1'b1, 1'b0, "R4 data ack");
    gen_stop;
    mdl_mem[a] = d;
    mdl_addr = (a + 1) % 16;
    chk(write_busy == 1'b1, "R5 busy after committed write", write_busy, 1);
    tick(WRC + 20);
    chk(write_busy == 1'b0, "R5 busy ends", write_busy, 0);
  endtask

  task automatic set_addr_and_read(input logic [3:0] a);
    gen_start;
    send_byte(DEVW, 1'b1, 1'b0, "R8 random read select");
    send_byte({4'h0, a}, 1'b1, 1'b0, "R8 random read address");
    mdl_addr = a;
    gen_start;
    send_byte(DEVR, 1'b1, ~mdl_mem[mdl_addr][7], "R8 read select ack");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mdl_mem[i] = 8'h00;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R12 reset state
    chk(sda_drive_low == 1'b0, "R12 sda released", sda_drive_low, 0);
    chk(write_busy == 1'b0, "R12 not busy", write_busy, 0);
    cmp_on = 1'b1;

    // R4 R5 byte write, then R6 select refused while busy
    gen_start;
    send_byte(DEVW, 1'b1, 1'b0, "R3 write select ack");
    send_byte(8'h03, 1'b1, 1'b0, "R4 address ack");
    send_byte(8'hA5, 1'b1, 1'b0, "R4 data ack");
    gen_stop;
    mdl_mem[3] = 8'hA5; mdl_addr = 4;
    chk(write_busy == 1'b1, "R5 busy after STOP", write_busy, 1);
    gen_start;
    send_byte(DEVW, 1'b0, 1'b0, "R6 no ack while busy");
    gen_stop;
    chk(write_busy == 1'b1, "R5 busy lasts", write_busy, 1);
    tick(WRC);
    chk(write_busy == 1'b0, "R5 busy ends", write_busy, 0);

    // R8 random read of address 3
    set_addr_and_read(4'd3);
    read_byte(8'hA5, 1'b0, 1'b0, "R7 random read data");
    mdl_addr = 4;
    gen_stop;

    // R8 current-address read uses counter 4 (all-zero byte)
    gen_start;
    send_byte(DEVR, 1'b1, ~mdl_mem[4][7], "R8 current read select");
    read_byte(mdl_mem[4], 1'b0, 1'b0, "R8 current read data");
    mdl_addr = 5;
    gen_stop;

    // R3 wrong select code ignored
    gen_start;
    send_byte(8'h92, 1'b0, 1'b0, "R3 foreign code no ack");
    send_byte(8'hFF, 1'b0, 1'b0, "R3 ignored after mismatch");
    gen_stop;
    chk(write_busy == 1'b0, "R3 no write from foreign code", write_busy, 0);

    // R5 STOP in mid data byte: nothing written, counter loaded (R4)
    gen_start;
    send_byte(DEVW, 1'b1, 1'b0, "R3 write select ack");
    send_byte(8'h07, 1'b1, 1'b0, "R4 address ack");
    for (int i = 0; i < 4; i++) clock_bit(~i[0], 1'b0, s);
    gen_stop;
    mdl_addr = 7;
    tick(5);
    chk(write_busy == 1'b0, "R5 mid-byte STOP no write", write_busy, 0);
    gen_start;
    send_byte(DEVR, 1'b1, ~mdl_mem[7][7], "R4 counter loaded by address");
    read_byte(mdl_mem[7], 1'b0, 1'b0, "R5 word unchanged");
    mdl_addr = 8;
    gen_stop;

    // R5 START after a full data byte aborts the write; R1
    gen_start;
    send_byte(DEVW, 1'b1, 1'b0, "R3 write select ack");
    send_byte(8'h09, 1'b1, 1'b0, "R4 address ack");
    send_byte(8'h5A, 1'b1, 1'b0, "R4 data ack");
    gen_start;
    gen_stop;
    tick(5);
    chk(write_busy == 1'b0, "R1 R5 START abort no write", write_busy, 0);
    set_addr_and_read(4'd9);
    read_byte(mdl_mem[9], 1'b0, 1'b0, "R5 aborted word unchanged");
    gen_stop;

    // R9 sequential read with wrap
    do_write(4'd14, 8'h81);
    do_write(4'd15, 8'h7E);
    set_addr_and_read(4'd14);
    read_byte(8'h81, 1'b1, ~mdl_mem[15][7], "R9 sequential byte 0");
    read_byte(8'h7E, 1'b1, ~mdl_mem[0][7], "R9 sequential byte 1");
    read_byte(mdl_mem[0], 1'b0, 1'b0, "R7 wrap to word 0");
    mdl_addr = 1;
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, 1'b0, s);
      chk(s == 1'b1, "R9 released after NoAck", s, 1);
    end
    gen_stop;

    // R11 master stops while the engine holds SDA low
    set_addr_and_read(4'd14);
    clock_bit(1'b1, 1'b1, s);
    chk(s == 1'b1, "R11 first bit", s, 1);
    clock_bit(1'b1, 1'b1, s);
    chk(s == 1'b0, "R11 second bit", s, 0);
    mdl_addr = 15;
    cmp_on = 1'b0;
    for (int i = 0; i < 9; i++) begin
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
    chk(sda_drive_low == 1'b0, "R11 released after recovery", sda_drive_low, 0);
    exp_drive = 1'b0; settle = 0; cmp_on = 1'b1;
    gen_start;
    send_byte(DEVR, 1'b1, ~mdl_mem[15][7], "R11 select after recovery");
    read_byte(mdl_mem[15], 1'b0, 1'b0, "R11 counter kept through abort");
    gen_stop;
    tick(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule